// File: doc/BRIEF.md
# Link Equalization Phase Sequencer

This block walks one serial-link port through the transmitter equalization phases that follow a change to the highest data rate. A role input selects whether the port faces downstream (it starts in phase 1) or upstream (it starts in phase 0). The block reads the phase code and field contents of each received training set, and a done indication from the local tuning logic. From these it builds the equalization fields of every training set it sends: the phase code, the use-preset flag, the preset and three coefficient fields.

Each phase has two roles. In one phase the port is the requester, and its outgoing fields come straight from the local tuning logic. In the other phase the port is tuned, and it echoes the settings its partner asks for. Phase 2 and phase 3 swap these two roles between the two ports. The block follows the partner's progress through the received phase code. A phase moves forward only on two consecutive matching training sets. A tick-driven watchdog aborts a phase that stalls. When the sequence ends, a one-cycle exit strobe tells the link training logic to return to receiver lock. On success the block also keeps a copy of the agreed transmitter setting.

Top module: `eq_phase_seq`

## Requirements
- R1: After reset the block is idle: busy=0, tx_ec=00, exit_pulse=0, eq_fail=0, and all saved and partner fields are zero.
- R2: A start pulse while idle enters phase 1 (tx_ec=01) when role_dn=1, or phase 0 (tx_ec=00) when role_dn=0, and raises busy on the next cycle.
- R3: On start the held setting becomes use-preset=1, with the preset taken from cfg_preset (downstream) or hint_preset (upstream) and all three coefficients zero.
- R4: A phase advance triggered by the partner needs two consecutive valid received sets whose rx_ec equals the awaited code. A valid set with any other code restarts the count. Cycles with rx_valid=0 do not break the run.
- R5: Awaited codes: upstream phase 0 waits for 01, downstream phase 1 waits for 01, upstream phase 1 waits for 10, downstream phase 2 waits for 11. tx_ec always equals the current phase number, and each advance raises it by exactly one.
- R6: In phase 1, tx_f7 and tx_f8 carry local_fs and local_lf. While in phase 0 or 1, any valid received set with rx_ec=01 loads partner_fs and partner_lf from rx_f7 and rx_f8.
- R7: In the requester phase (upstream phase 2, downstream phase 3), the outgoing use-preset, preset and coefficient fields equal the req_* inputs in the same cycle.
- R8: In the tuned phase (downstream phase 2, upstream phase 3), a valid received set whose rx_ec equals the current phase code loads the held setting from the rx fields. The new setting appears on the outgoing fields one cycle later. Outside phase 1 and the requester phase, the outgoing fields show the held setting.
- R9: tune_done in the requester phase ends it: upstream phase 2 goes to phase 3, and downstream phase 3 finishes the sequence. tune_done has no effect in any other phase.
- R10: The upstream port finishes phase 3 after two consecutive valid received sets with rx_ec=00.
- R11: A successful finish returns the block to idle, raises exit_pulse for exactly one cycle and copies the held setting into the saved_* outputs.
- R12: The TMO_LIMIT-th tmo_tick within a single phase forces the block to idle, with exit_pulse and eq_fail set and saved_* left unchanged. The tick count restarts at every phase change. A timeout takes priority over an advance in the same cycle. eq_fail stays set until the next start.
- R13: start has no effect while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| role_dn | input | 1 | 1 = downstream-facing port, 0 = upstream-facing port |
| start | input | 1 | Begin the equalization sequence |
| cfg_preset | input | PW | Initial preset of a downstream port |
| hint_preset | input | PW | Initial preset of an upstream port, received during configuration |
| local_fs | input | CW | Local full-swing value sent in phase 1 |
| local_lf | input | CW | Local low-frequency value sent in phase 1 |
| rx_valid | input | 1 | A received training set is present this cycle |
| rx_ec | input | 2 | Received phase code |
| rx_use_preset | input | 1 | Received use-preset flag |
| rx_preset | input | PW | Received preset field |
| rx_f7 | input | CW | Received pre-cursor / FS field |
| rx_f8 | input | CW | Received cursor / LF field |
| rx_f9 | input | CW | Received post-cursor field |
| tune_done | input | 1 | Local tuning logic reports that the partner's setting is good |
| req_use_preset | input | 1 | Requested use-preset flag |
| req_preset | input | PW | Requested preset |
| req_pre | input | CW | Requested pre-cursor coefficient |
| req_cur | input | CW | Requested cursor coefficient |
| req_post | input | CW | Requested post-cursor coefficient |
| tmo_tick | input | 1 | Watchdog time base |
| busy | output | 1 | A phase is in progress |
| tx_ec | output | 2 | Outgoing phase code |
| tx_use_preset | output | 1 | Outgoing use-preset flag |
| tx_preset | output | PW | Outgoing preset field |
| tx_f7 | output | CW | Outgoing pre-cursor / FS field |
| tx_f8 | output | CW | Outgoing cursor / LF field |
| tx_f9 | output | CW | Outgoing post-cursor field |
| exit_pulse | output | 1 | One-cycle strobe: return to receiver lock |
| eq_fail | output | 1 | The last sequence ended by timeout |
| partner_fs | output | CW | Partner full-swing value captured in phase 0/1 |
| partner_lf | output | CW | Partner low-frequency value captured in phase 0/1 |
| saved_use_preset | output | 1 | Agreed use-preset flag |
| saved_preset | output | PW | Agreed preset |
| saved_pre | output | CW | Agreed pre-cursor |
| saved_cur | output | CW | Agreed cursor |
| saved_post | output | CW | Agreed post-cursor |

## Verification
Inputs sampled at one edge show their effect after that edge. A phase change, a timeout, an echoed setting, captured FS/LF, the saved setting and exit_pulse all change on the cycle after the qualifying input, with no further delay. The requester-phase outputs are combinational and follow req_* in the same cycle. The bench drives inputs just after a falling edge and compares every output against a behavioural model at the next falling edge. Each result is therefore checked in exactly the cycle it is due. Directed runs cover both roles, interrupted qualification runs, ignored start and tune_done, and timeout. A long stretch of random stimulus follows them.

// File: rtl/eq_phase_seq.sv
module eq_phase_seq #(
  parameter int TMO_LIMIT = 1024,
  parameter int CW = 6,
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          role_dn,
  input  logic          start,
  input  logic [PW-1:0] cfg_preset,
  input  logic [PW-1:0] hint_preset,
  input  logic [CW-1:0] local_fs,
  input  logic [CW-1:0] local_lf,
  input  logic          rx_valid,
  input  logic [1:0]    rx_ec,
  input  logic          rx_use_preset,
  input  logic [PW-1:0] rx_preset,
  input  logic [CW-1:0] rx_f7,
  input  logic [CW-1:0] rx_f8,
  input  logic [CW-1:0] rx_f9,
  input  logic          tune_done,
  input  logic          req_use_preset,
  input  logic [PW-1:0] req_preset,
  input  logic [CW-1:0] req_pre,
  input  logic [CW-1:0] req_cur,
  input  logic [CW-1:0] req_post,
  input  logic          tmo_tick,
  output logic          busy,
  output logic [1:0]    tx_ec,
  output logic          tx_use_preset,
  output logic [PW-1:0] tx_preset,
  output logic [CW-1:0] tx_f7,
  output logic [CW-1:0] tx_f8,
  output logic [CW-1:0] tx_f9,
  output logic          exit_pulse,
  output logic          eq_fail,
  output logic [CW-1:0] partner_fs,
  output logic [CW-1:0] partner_lf,
  output logic          saved_use_preset,
  output logic [PW-1:0] saved_preset,
  output logic [CW-1:0] saved_pre,
  output logic [CW-1:0] saved_cur,
  output logic [CW-1:0] saved_post
);
  localparam int TW = $clog2(TMO_LIMIT + 1);

  typedef enum logic [2:0] {S_IDLE, S_P0, S_P1, S_P2, S_P3} st_t;
  st_t st;

  logic          qcnt;
  logic [TW-1:0] tcnt;
  logic          h_use;
  logic [PW-1:0] h_preset;
  logic [CW-1:0] h_pre, h_cur, h_post;
  logic [1:0]    ph, tgt;

  always_comb begin
    case (st)
      S_P1:    ph = 2'b01;
      S_P2:    ph = 2'b10;
      S_P3:    ph = 2'b11;
      default: ph = 2'b00;
    endcase
    case (st)
      S_P0:    tgt = 2'b01;
      S_P1:    tgt = role_dn ? 2'b01 : 2'b10;
      S_P2:    tgt = 2'b11;
      default: tgt = 2'b00;
    endcase
  end

  assign busy = (st != S_IDLE);
  assign tx_ec = ph;

  wire requester = (st == S_P2 && !role_dn) || (st == S_P3 && role_dn);
  wire tuned     = (st == S_P2 && role_dn) || (st == S_P3 && !role_dn);
  wire qual_en   = busy && !requester;
  wire hit       = qual_en && rx_valid && (rx_ec == tgt);
  wire advance   = (hit && qcnt) || (requester && tune_done);
  wire timeout   = busy && tmo_tick && (tcnt == TW'(TMO_LIMIT - 1));
  wire finish    = advance && (st == S_P3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      qcnt <= 1'b0;
      tcnt <= '0;
      exit_pulse <= 1'b0;
      eq_fail <= 1'b0;
      saved_use_preset <= 1'b0;
      saved_preset <= '0;
      saved_pre <= '0;
      saved_cur <= '0;
      saved_post <= '0;
    end else begin
      exit_pulse <= 1'b0;
      if (!busy) begin
        if (start) begin
          st <= role_dn ? S_P1 : S_P0;
          qcnt <= 1'b0;
          tcnt <= '0;
          eq_fail <= 1'b0;
        end
      end else if (timeout) begin
        st <= S_IDLE;
        exit_pulse <= 1'b1;
        eq_fail <= 1'b1;
      end else if (finish) begin
        st <= S_IDLE;
        exit_pulse <= 1'b1;
        saved_use_preset <= h_use;
        saved_preset <= h_preset;
        saved_pre <= h_pre;
        saved_cur <= h_cur;
        saved_post <= h_post;
      end else if (advance) begin
        st <= st_t'(st + 3'd1);
        qcnt <= 1'b0;
        tcnt <= '0;
      end else begin
        if (qual_en && rx_valid) qcnt <= hit;
        if (tmo_tick) tcnt <= tcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_use <= 1'b0;
      h_preset <= '0;
      h_pre <= '0;
      h_cur <= '0;
      h_post <= '0;
    end else if (!busy && start) begin
      h_use <= 1'b1;
      h_preset <= role_dn ? cfg_preset : hint_preset;
      h_pre <= '0;
      h_cur <= '0;
      h_post <= '0;
    end else if (tuned && rx_valid && rx_ec == ph) begin
      h_use <= rx_use_preset;
      h_preset <= rx_preset;
      h_pre <= rx_f7;
      h_cur <= rx_f8;
      h_post <= rx_f9;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      partner_fs <= '0;
      partner_lf <= '0;
    end else if ((st == S_P0 || st == S_P1) && rx_valid && rx_ec == 2'b01) begin
      partner_fs <= rx_f7;
      partner_lf <= rx_f8;
    end
  end

  always_comb begin
    if (requester) begin
      tx_use_preset = req_use_preset;
      tx_preset = req_preset;
      tx_f7 = req_pre;
      tx_f8 = req_cur;
      tx_f9 = req_post;
    end else if (st == S_P1) begin
      tx_use_preset = h_use;
      tx_preset = h_preset;
      tx_f7 = local_fs;
      tx_f8 = local_lf;
      tx_f9 = h_post;
    end else begin
      tx_use_preset = h_use;
      tx_preset = h_preset;
      tx_f7 = h_pre;
      tx_f8 = h_cur;
      tx_f9 = h_post;
    end
  end

  p_start_dn_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && role_dn) |=> (busy && tx_ec == 2'b01));

  p_ec_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && tx_ec != $past(tx_ec)) |-> (tx_ec == $past(tx_ec) + 2'd1));

  p_exit_one_r11: assert property (@(posedge clk) disable iff (!rst_n)
    exit_pulse |=> !exit_pulse);

  p_exit_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    exit_pulse |-> !busy);

  p_fail_rise_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eq_fail) |-> exit_pulse);

  p_saved_kept_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_pulse && eq_fail) |-> ($stable(saved_preset) && $stable(saved_cur)));

  p_busy_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !tmo_tick && !tune_done && !rx_valid) |=> busy);
endmodule

// File: tb/tb_eq_phase_seq.sv
module tb_eq_phase_seq;
  localparam int LIM = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic role_dn = 1'b0, start = 1'b0, rx_valid = 1'b0, rx_use_preset = 1'b0;
  logic tune_done = 1'b0, req_use_preset = 1'b0, tmo_tick = 1'b0;
  logic [3:0] cfg_preset = 4'd5, hint_preset = 4'd7, rx_preset = '0, req_preset = '0;
  logic [5:0] local_fs = 6'd44, local_lf = 6'd12;
  logic [5:0] rx_f7 = '0, rx_f8 = '0, rx_f9 = '0, req_pre = '0, req_cur = '0, req_post = '0;
  logic [1:0] rx_ec = '0;

  logic busy, tx_use_preset, exit_pulse, eq_fail, saved_use_preset;
  logic [1:0] tx_ec;
  logic [3:0] tx_preset, saved_preset;
  logic [5:0] tx_f7, tx_f8, tx_f9, partner_fs, partner_lf, saved_pre, saved_cur, saved_post;

  eq_phase_seq #(.TMO_LIMIT(LIM), .CW(6), .PW(4)) dut (
    .clk(clk), .rst_n(rst_n), .role_dn(role_dn), .start(start),
    .cfg_preset(cfg_preset), .hint_preset(hint_preset), .local_fs(local_fs), .local_lf(local_lf),
    .rx_valid(rx_valid), .rx_ec(rx_ec), .rx_use_preset(rx_use_preset), .rx_preset(rx_preset),
    .rx_f7(rx_f7), .rx_f8(rx_f8), .rx_f9(rx_f9), .tune_done(tune_done),
    .req_use_preset(req_use_preset), .req_preset(req_preset), .req_pre(req_pre),
    .req_cur(req_cur), .req_post(req_post), .tmo_tick(tmo_tick),
    .busy(busy), .tx_ec(tx_ec), .tx_use_preset(tx_use_preset), .tx_preset(tx_preset),
    .tx_f7(tx_f7), .tx_f8(tx_f8), .tx_f9(tx_f9), .exit_pulse(exit_pulse), .eq_fail(eq_fail),
    .partner_fs(partner_fs), .partner_lf(partner_lf), .saved_use_preset(saved_use_preset),
    .saved_preset(saved_preset), .saved_pre(saved_pre), .saved_cur(saved_cur), .saved_post(saved_post)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // behavioural model: phase number -1 = idle
  int m_ph = -1, m_q = 0, m_t = 0, m_exit = 0, m_fail = 0;
  int m_hold = 0, m_saved = 0, m_pfs = 0, m_plf = 0;

  function automatic int pack(input logic u, input logic [3:0] p, input logic [5:0] a,
                              input logic [5:0] b, input logic [5:0] c);
    return int'({u, p, a, b, c});
  endfunction

  function automatic bit m_req();
    return (m_ph == 2 && !role_dn) || (m_ph == 3 && role_dn);
  endfunction

  function automatic bit m_tuned();
    return (m_ph == 2 && role_dn) || (m_ph == 3 && !role_dn);
  endfunction

  function automatic int m_wait();
    case (m_ph)
      0: return 1;
      1: return role_dn ? 1 : 2;
      2: return 3;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = -1; m_q = 0; m_t = 0; m_exit = 0; m_fail = 0;
      m_hold = 0; m_saved = 0; m_pfs = 0; m_plf = 0;
    end else begin
      automatic bit req = m_req();
      automatic bit tnd = m_tuned();
      automatic int ph = m_ph;
      automatic bit adv = 0;
      m_exit = 0;
      if (ph < 0) begin
        if (start) begin
          m_ph = role_dn ? 1 : 0;
          m_hold = pack(1'b1, role_dn ? cfg_preset : hint_preset, 6'd0, 6'd0, 6'd0);
          m_fail = 0; m_q = 0; m_t = 0;
        end
      end else begin
        if (!req && rx_valid) begin
          if (int'(rx_ec) == m_wait()) begin
            if (m_q == 1) adv = 1;
            m_q = 1;
          end else m_q = 0;
        end
        if (req && tune_done) adv = 1;
        if (tmo_tick && m_t == LIM - 1) begin
          m_ph = -1; m_exit = 1; m_fail = 1;
        end else if (adv) begin
          m_q = 0; m_t = 0;
          if (ph == 3) begin m_ph = -1; m_exit = 1; m_saved = m_hold; end
          else m_ph = ph + 1;
        end else if (tmo_tick) m_t = m_t + 1;
        if ((ph == 0 || ph == 1) && rx_valid && rx_ec == 2'b01) begin
          m_pfs = int'(rx_f7); m_plf = int'(rx_f8);
        end
        if (tnd && rx_valid && int'(rx_ec) == ph)
          m_hold = pack(rx_use_preset, rx_preset, rx_f7, rx_f8, rx_f9);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    int e_tx;
    string tg;
    chk("R5", int'(tx_ec), m_ph < 0 ? 0 : m_ph);
    chk("R2", int'(busy), m_ph >= 0 ? 1 : 0);
    if (m_req()) begin
      e_tx = pack(req_use_preset, req_preset, req_pre, req_cur, req_post); tg = "R7";
    end else if (m_ph == 1) begin
      e_tx = (m_hold & ~(32'hFFF << 6)) | (int'(local_fs) << 12) | (int'(local_lf) << 6); tg = "R6";
    end else begin
      e_tx = m_hold; tg = "R8";
    end
    chk(tg, pack(tx_use_preset, tx_preset, tx_f7, tx_f8, tx_f9), e_tx);
    chk("R11", int'(exit_pulse), m_exit);
    chk("R12", int'(eq_fail), m_fail);
    chk("R11", pack(saved_use_preset, saved_preset, saved_pre, saved_cur, saved_post), m_saved);
    chk("R6", int'({partner_fs, partner_lf}), (m_pfs << 6) | m_plf);
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
  endtask

  task automatic ts(input logic [1:0] ec, input logic u, input logic [3:0] p,
                    input logic [5:0] a, input logic [5:0] b, input logic [5:0] c);
    rx_valid = 1; rx_ec = ec; rx_use_preset = u; rx_preset = p; rx_f7 = a; rx_f8 = b; rx_f9 = c;
    tick();
    rx_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    // R1 reset state
    chk("R1", int'(busy), 0); chk("R1", int'(tx_ec), 0);
    chk("R1", int'(exit_pulse), 0); chk("R1", int'(eq_fail), 0);
    chk("R1", int'(saved_preset), 0); chk("R1", int'(partner_fs), 0);

    // downstream flow
    role_dn = 1; cfg_preset = 4'd5; start = 1; tick(); start = 0;
    chk("R2", int'(tx_ec), 1); chk("R3", int'(tx_preset), 5); chk("R3", int'(tx_use_preset), 1);
    ts(2'b01, 0, 0, 6'd30, 6'd8, 0);
    chk("R6", int'(partner_fs), 30);
    ts(2'b11, 0, 0, 0, 0, 0);
    ts(2'b01, 0, 0, 6'd30, 6'd8, 0);
    chk("R4", int'(tx_ec), 1);
    tick();
    ts(2'b01, 0, 0, 6'd30, 6'd8, 0);
    chk("R4", int'(tx_ec), 2);
    ts(2'b10, 0, 4'd2, 6'd3, 6'd40, 6'd7);
    chk("R8", int'(tx_f8), 40); chk("R8", int'(tx_use_preset), 0);
    tune_done = 1; tick(); tune_done = 0;
    chk("R9", int'(tx_ec), 2);
    ts(2'b11, 0, 0, 0, 0, 0);
    ts(2'b11, 0, 0, 0, 0, 0);
    chk("R5", int'(tx_ec), 3);
    req_use_preset = 1; req_preset = 4'd9; tick();
    chk("R7", int'(tx_preset), 9);
    tune_done = 1; tick(); tune_done = 0;
    chk("R9", int'(exit_pulse), 1); chk("R11", int'(busy), 0);
    chk("R11", int'(saved_cur), 40); chk("R11", int'(saved_use_preset), 0);
    tick();
    chk("R11", int'(exit_pulse), 0);

    // upstream flow
    role_dn = 0; hint_preset = 4'd7; start = 1; tick(); start = 0;
    chk("R2", int'(tx_ec), 0); chk("R2", int'(busy), 1); chk("R3", int'(tx_preset), 7);
    ts(2'b01, 0, 0, 6'd20, 6'd9, 0);
    ts(2'b01, 0, 0, 6'd20, 6'd9, 0);
    chk("R5", int'(tx_ec), 1); chk("R6", int'(partner_fs), 20); chk("R6", int'(tx_f7), 44);
    start = 1; tick(); start = 0;
    chk("R13", int'(tx_ec), 1);
    ts(2'b10, 0, 0, 0, 0, 0);
    ts(2'b10, 0, 0, 0, 0, 0);
    chk("R5", int'(tx_ec), 2);
    tune_done = 1; tick(); tune_done = 0;
    chk("R9", int'(tx_ec), 3);
    ts(2'b11, 1, 4'd4, 0, 0, 0);
    chk("R8", int'(tx_preset), 4);
    ts(2'b00, 0, 0, 0, 0, 0);
    ts(2'b00, 0, 0, 0, 0, 0);
    chk("R10", int'(exit_pulse), 1); chk("R10", int'(saved_preset), 4);

    // timeout
    role_dn = 1; start = 1; tick(); start = 0;
    for (int i = 0; i < LIM - 1; i++) begin tmo_tick = 1; tick(); tmo_tick = 0; tick(); end
    chk("R12", int'(busy), 1);
    tmo_tick = 1; tick(); tmo_tick = 0;
    chk("R12", int'(eq_fail), 1); chk("R12", int'(exit_pulse), 1); chk("R12", int'(saved_preset), 4);

    // random traffic
    for (int i = 0; i < 6000; i++) begin
      if (m_ph < 0) role_dn = $urandom_range(0, 1);
      start = ($urandom_range(0, 15) == 0);
      rx_valid = $urandom_range(0, 1);
      rx_ec = 2'($urandom_range(0, 3));
      rx_use_preset = $urandom_range(0, 1);
      rx_preset = 4'($urandom); rx_f7 = 6'($urandom); rx_f8 = 6'($urandom); rx_f9 = 6'($urandom);
      tune_done = ($urandom_range(0, 15) == 0);
      tmo_tick = ($urandom_range(0, 7) == 0);
      req_use_preset = $urandom_range(0, 1);
      req_preset = 4'($urandom); req_pre = 6'($urandom); req_cur = 6'($urandom); req_post = 6'($urandom);
      cfg_preset = 4'($urandom); hint_preset = 4'($urandom);
      tick();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule